// File: doc/BRIEF.md
# Two-Road Timed Traffic Light Sequencer

This block drives the red, yellow and green lamps of two crossing roads. It steps them through a fixed cycle of four phases: road 1 go, road 1 warn, road 2 go, road 2 warn. Time is measured in ticks. Each tick is a one-cycle enable pulse that normally stands for half a second. An elapsed-tick counter grows on every tick. When the counter reaches the last tick of the current phase, the sequencer does two things on the same tick: it clears the counter and moves to the next phase. The go phases default to 90 ticks (45 s) and the warn phases to 30 ticks (15 s).

The tick comes in on a clock-enable input. An optional prescaler passes on one of every `TICK_DIV` incoming pulses. Tying the input high and setting `TICK_DIV` to the clock rate divided by two therefore makes the half-second tick from the system clock. A demand input for road 2 can shorten road 1's go phase, but only after a minimum go time has passed.

Top module: `trafficSequencer`

## Requirements
- R1: A synchronous reset puts the sequencer in phase 00 (road 1 green, road 2 red) with zero elapsed ticks.
- R2: The phase code on `phaseOut` runs 00, 01, 10, 11 and then wraps to 00. It never skips a code and never goes backwards.
- R3: The lamps follow the phase code. 00 gives road 1 green and road 2 red. 01 gives road 1 yellow and road 2 red. 10 gives road 1 red and road 2 green. 11 gives road 1 red and road 2 yellow.
- R4: Exactly one lamp per road is lit in every cycle, and at least one of the two roads always shows red.
- R5: With no demand, each go phase lasts `GREEN_TICKS` ticks and each warn phase lasts `YELLOW_TICKS` ticks. A phase ends on the tick that arrives while the elapsed count equals its duration minus one.
- R6: Without a tick, neither the elapsed count nor the phase changes. A phase that is paused resumes with the ticks it had left.
- R7: The elapsed count is cleared on the same tick that the phase advances, so every new phase gets its full duration.
- R8: In phase 00, a tick that arrives while `road2Demand` is high and the elapsed count is at least `MIN_GREEN_TICKS`-1 ends the phase. Demand on earlier ticks has no effect.
- R9: `road2Demand` has no effect in phases 01, 10 and 11.
- R10: With `TICK_DIV` of 2 or more, only every `TICK_DIV`-th `tickIn` pulse counts as a tick. With 0 or 1, every pulse counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tickIn | input | 1 | Time-base enable pulse, prescaled by `TICK_DIV` |
| road2Demand | input | 1 | Vehicle or pedestrian waiting on road 2 |
| phaseOut | output | 2 | Current phase code |
| road1Red | output | 1 | Road 1 red lamp |
| road1Yellow | output | 1 | Road 1 yellow lamp |
| road1Green | output | 1 | Road 1 green lamp |
| road2Red | output | 1 | Road 2 red lamp |
| road2Yellow | output | 1 | Road 2 yellow lamp |
| road2Green | output | 1 | Road 2 green lamp |

## Verification
Properties check these rules on every cycle:
- one lamp per road, with one road always red;
- the phase only ever steps forward by one;
- the counter is cleared on each phase change and stays inside the current phase's duration;
- nothing moves without a tick;
- road 1's go phase is never cut short before its minimum.

Only the bench scenarios can show that the phase lengths are exact. They do this by counting ticks:
- the go and warn lengths with no demand;
- pauses in the middle of a phase;
- demand raised before and after the minimum;
- demand in the other phases;
- the prescaler's ratio.

// File: rtl/tlsPkg.sv
`timescale 1ns/1ps
package tlsPkg;

  typedef enum logic [1:0] {
    PH_A_GO   = 2'b00,
    PH_A_WARN = 2'b01,
    PH_B_GO   = 2'b10,
    PH_B_WARN = 2'b11
  } phaseT;

  // strobes from control to the elapsed-time datapath
  typedef struct packed {
    logic clear;
    logic step;
  } tmrCtlT;

  typedef struct packed {
    logic red;
    logic yellow;
    logic green;
  } lampT;

endpackage

// File: rtl/tlsTickGen.sv
`timescale 1ns/1ps
module tlsTickGen #(
  parameter int TICK_DIV = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic tickIn,
  output logic tickOut
);

  generate
    if (TICK_DIV <= 1) begin : gPass
      assign tickOut = tickIn;
    end else begin : gDiv
      localparam int DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] divCnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          divCnt <= '0;
        end else if (tickIn) begin
          if (divCnt == LAST) divCnt <= '0;
          else                divCnt <= divCnt + 1'b1;
        end
      end

      assign tickOut = tickIn && (divCnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/tlsTimerPath.sv
`timescale 1ns/1ps
module tlsTimerPath #(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  tlsPkg::tmrCtlT    ctl,
  output logic [CNT_W-1:0]  elapsed
);

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) elapsed <= '0;
    else if (ctl.step)    elapsed <= elapsed + 1'b1;
  end

endmodule

// File: rtl/tlsPhaseCtl.sv
`timescale 1ns/1ps
module tlsPhaseCtl #(
  parameter int GREEN_TICKS     = 90,
  parameter int YELLOW_TICKS    = 30,
  parameter int MIN_GREEN_TICKS = 20,
  parameter int CNT_W           = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              demand,
  input  logic [CNT_W-1:0]  elapsed,
  output tlsPkg::tmrCtlT    ctl,
  output tlsPkg::phaseT     phase,
  output tlsPkg::lampT      lampA,
  output tlsPkg::lampT      lampB
);
  import tlsPkg::*;

  localparam logic [CNT_W-1:0] GO_LAST   = CNT_W'(GREEN_TICKS - 1);
  localparam logic [CNT_W-1:0] WARN_LAST = CNT_W'(YELLOW_TICKS - 1);
  localparam logic [CNT_W-1:0] MIN_LAST  = CNT_W'(MIN_GREEN_TICKS - 1);

  logic [CNT_W-1:0] lastTick;
  logic             timeUp;
  logic             earlyCut;
  logic             endNow;

  always_comb begin
    lastTick = phase[0] ? WARN_LAST : GO_LAST;
    timeUp   = (elapsed == lastTick);
    earlyCut = (phase == PH_A_GO) && demand && (elapsed >= MIN_LAST);
    endNow   = tick && (timeUp || earlyCut);
    ctl.clear = endNow;
    ctl.step  = tick && !endNow;
  end

  always_ff @(posedge clk) begin
    if (rst)         phase <= PH_A_GO;
    else if (endNow) phase <= phaseT'(phase + 2'd1);
  end

  always_comb begin
    lampA = '{red: 1'b1, yellow: 1'b0, green: 1'b0};
    lampB = '{red: 1'b1, yellow: 1'b0, green: 1'b0};
    case (phase)
      PH_A_GO:   lampA = '{red: 1'b0, yellow: 1'b0, green: 1'b1};
      PH_A_WARN: lampA = '{red: 1'b0, yellow: 1'b1, green: 1'b0};
      PH_B_GO:   lampB = '{red: 1'b0, yellow: 1'b0, green: 1'b1};
      PH_B_WARN: lampB = '{red: 1'b0, yellow: 1'b1, green: 1'b0};
      default: ;
    endcase
  end

endmodule

// File: rtl/trafficSequencer.sv
`timescale 1ns/1ps
module trafficSequencer #(
  parameter int GREEN_TICKS     = 90,
  parameter int YELLOW_TICKS    = 30,
  parameter int MIN_GREEN_TICKS = 20,
  parameter int TICK_DIV        = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickIn,
  input  logic       road2Demand,
  output logic [1:0] phaseOut,
  output logic       road1Red,
  output logic       road1Yellow,
  output logic       road1Green,
  output logic       road2Red,
  output logic       road2Yellow,
  output logic       road2Green
);
  import tlsPkg::*;

  localparam int MAX_TICKS = (GREEN_TICKS > YELLOW_TICKS) ? GREEN_TICKS : YELLOW_TICKS;
  localparam int CNT_W     = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;

  logic             tickEff;
  logic [CNT_W-1:0] elapsedCnt;
  tmrCtlT           tmrCtl;
  phaseT            phase;
  lampT             lampA;
  lampT             lampB;

  tlsTickGen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tickIn(tickIn), .tickOut(tickEff)
  );

  tlsPhaseCtl #(
    .GREEN_TICKS(GREEN_TICKS), .YELLOW_TICKS(YELLOW_TICKS),
    .MIN_GREEN_TICKS(MIN_GREEN_TICKS), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .tick(tickEff), .demand(road2Demand),
    .elapsed(elapsedCnt), .ctl(tmrCtl), .phase(phase),
    .lampA(lampA), .lampB(lampB)
  );

  tlsTimerPath #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .ctl(tmrCtl), .elapsed(elapsedCnt)
  );

  assign phaseOut    = phase;
  assign road1Red    = lampA.red;
  assign road1Yellow = lampA.yellow;
  assign road1Green  = lampA.green;
  assign road2Red    = lampB.red;
  assign road2Yellow = lampB.yellow;
  assign road2Green  = lampB.green;

endmodule

// File: rtl/tlsChecker.sv
`timescale 1ns/1ps
module tlsChecker #(
  parameter int GREEN_TICKS     = 90,
  parameter int YELLOW_TICKS    = 30,
  parameter int MIN_GREEN_TICKS = 20,
  parameter int CNT_W           = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             tickEff,
  input logic [CNT_W-1:0] elapsedCnt,
  input logic [1:0]       phaseOut,
  input logic             road1Red,
  input logic             road1Yellow,
  input logic             road1Green,
  input logic             road2Red,
  input logic             road2Yellow,
  input logic             road2Green
);

  logic [CNT_W:0] durNow;
  assign durNow = phaseOut[0] ? (CNT_W+1)'(YELLOW_TICKS) : (CNT_W+1)'(GREEN_TICKS);

  AST_ONE_LAMP_ROAD1: assert property (@(posedge clk) disable iff (rst)
    $countones({road1Red, road1Yellow, road1Green}) == 1); // R4
  AST_ONE_LAMP_ROAD2: assert property (@(posedge clk) disable iff (rst)
    $countones({road2Red, road2Yellow, road2Green}) == 1); // R4
  AST_ONE_ROAD_RED: assert property (@(posedge clk) disable iff (rst)
    road1Red || road2Red); // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (phaseOut != $past(phaseOut)) |-> (phaseOut == 2'($past(phaseOut) + 2'd1))); // R2
  AST_CLEAR_ON_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (phaseOut != $past(phaseOut)) |-> (elapsedCnt == '0)); // R7
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, elapsedCnt} < durNow)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tickEff |=> ($stable(phaseOut) && $stable(elapsedCnt))); // R6
  AST_MIN_GREEN: assert property (@(posedge clk) disable iff (rst)
    ($past(phaseOut) == 2'b00 && phaseOut == 2'b01) |->
      ($past(elapsedCnt) >= CNT_W'(MIN_GREEN_TICKS - 1))); // R8

endmodule

bind trafficSequencer tlsChecker #(
  .GREEN_TICKS(GREEN_TICKS), .YELLOW_TICKS(YELLOW_TICKS),
  .MIN_GREEN_TICKS(MIN_GREEN_TICKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .tickEff(tickEff), .elapsedCnt(elapsedCnt),
  .phaseOut(phaseOut),
  .road1Red(road1Red), .road1Yellow(road1Yellow), .road1Green(road1Green),
  .road2Red(road2Red), .road2Yellow(road2Yellow), .road2Green(road2Green)
);

// File: tb/trafficSequencer_tb.sv
`timescale 1ns/1ps
module trafficSequencer_tb;

  localparam int G   = 90;
  localparam int Y   = 30;
  localparam int MIN = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickIn = 1'b0;
  logic dem = 1'b0;
  logic [1:0] phaseOut;
  logic r1r, r1y, r1g, r2r, r2y, r2g;
  logic [1:0] divPhase;
  logic d1r, d1y, d1g, d2r, d2y, d2g;

  int errors = 0;
  int checks = 0;
  int mPhase = 0;
  int mCnt = 0;
  bit started = 0;
  int divTicks = 0;
  int divAt = -1;
  bit divSeen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trafficSequencer u_dut (
    .clk(clk), .rst(rst), .tickIn(tickIn), .road2Demand(dem),
    .phaseOut(phaseOut),
    .road1Red(r1r), .road1Yellow(r1y), .road1Green(r1g),
    .road2Red(r2r), .road2Yellow(r2y), .road2Green(r2g)
  );

  trafficSequencer #(.GREEN_TICKS(4), .YELLOW_TICKS(2), .MIN_GREEN_TICKS(2), .TICK_DIV(3)) u_div (
    .clk(clk), .rst(rst), .tickIn(tickIn), .road2Demand(1'b0),
    .phaseOut(divPhase),
    .road1Red(d1r), .road1Yellow(d1y), .road1Green(d1g),
    .road2Red(d2r), .road2Yellow(d2y), .road2Green(d2g)
  );

  function automatic logic [5:0] expLamps(input int ph);
    case (ph)
      0:       return 6'b001_100;
      1:       return 6'b010_100;
      2:       return 6'b100_001;
      default: return 6'b100_010;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase index and elapsed ticks
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mPhase = 0; mCnt = 0;
    end else if (tickIn) begin
      int dur;
      bit fin;
      dur = (mPhase % 2 == 0) ? G : Y;
      fin = (mCnt == dur - 1) || (mPhase == 0 && dem && mCnt >= MIN - 1);
      if (fin) begin mCnt = 0; mPhase = (mPhase + 1) % 4; end
      else mCnt++;
    end
    if (rst) divTicks = 0;
    else if (tickIn) divTicks++;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      logic [5:0] lamps;
      lamps = {r1r, r1y, r1g, r2r, r2y, r2g};
      check(phaseOut == 2'(mPhase), "R2 phase vs model", phaseOut, mPhase);
      check(lamps == expLamps(mPhase), "R3 lamps vs phase", lamps, expLamps(mPhase));
      check($countones(lamps[5:3]) == 1 && $countones(lamps[2:0]) == 1 && (r1r || r2r),
            "R4 one lamp per road", lamps, expLamps(mPhase));
      if (!rst && !divSeen && divPhase != 2'b00) begin
        divSeen = 1; divAt = divTicks;
      end
    end
  end

  task automatic measure(output int n);
    logic [1:0] ph0;
    n = 0;
    ph0 = phaseOut;
    tickIn = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (phaseOut == ph0 && n < 300);
    tickIn = 1'b0;
  endtask

  task automatic tickN(input int n);
    tickIn = 1'b1;
    repeat (n) @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(phaseOut == 2'b00, "R1 reset phase", phaseOut, 0);
    check({r1r, r1y, r1g, r2r, r2y, r2g} == 6'b001_100, "R1 reset lamps",
          {r1r, r1y, r1g, r2r, r2y, r2g}, 6'b001_100);
    rst = 1'b0;
    // R5 / R7 durations of a full cycle, R2 order
    measure(n); check(n == G, "R5 go phase 00 length", n, G);
    check(phaseOut == 2'b01, "R2 next is 01", phaseOut, 1);
    measure(n); check(n == Y, "R7 warn phase full length", n, Y);
    measure(n); check(n == G, "R5 go phase 10 length", n, G);
    measure(n); check(n == Y, "R5 warn phase 11 length", n, Y);
    check(phaseOut == 2'b00, "R2 wrap to 00", phaseOut, 0);
    // R6 pause
    repeat (40) @(negedge clk);
    check(phaseOut == 2'b00, "R6 no tick holds phase", phaseOut, 0);
    tickN(10);
    repeat (20) @(negedge clk);
    measure(n); check(n == G - 10, "R6 paused phase resumes", n, G - 10);
    measure(n); measure(n); measure(n);
    // R8 demand from the start ends at minimum
    dem = 1'b1;
    measure(n); check(n == MIN, "R8 demand cuts at minimum", n, MIN);
    // R9 demand ignored elsewhere
    measure(n); check(n == Y, "R9 demand in 01", n, Y);
    measure(n); check(n == G, "R9 demand in 10", n, G);
    measure(n); check(n == Y, "R9 demand in 11", n, Y);
    // R8 demand only before minimum has no effect
    tickN(MIN - 2);
    dem = 1'b0;
    check(phaseOut == 2'b00, "R8 early demand no cut", phaseOut, 0);
    measure(n); check(n == G - (MIN - 2), "R8 early demand no cut length", n, G - (MIN - 2));
    measure(n); measure(n); measure(n);
    // R8 late demand ends on next tick
    tickN(50);
    dem = 1'b1;
    measure(n); check(n == 1, "R8 late demand next tick", n, 1);
    dem = 1'b0;
    // R10 prescaler: go phase of 4 ticks at 1 of 3 pulses
    check(divSeen && divAt == 12, "R10 prescaled go length", divAt, 12);
    finishRun();
  end

endmodule